// File: doc/BRIEF.md
# Multifunction ALU with Class Select

This block is the arithmetic and logic unit of a simple 32-bit load/store datapath. It takes two operands, `x_i` and `y_i`, and a control word made of four independent fields. A 2-bit function class picks which functional unit drives the result. A single add/subtract bit sets the adder mode. A 3-bit shift field picks a constant shift of `y_i`. A 2-bit logic select picks one of four bitwise functions. Each field is decoded by its own unit, so the instruction decoder sets only the fields that an instruction needs and the other fields have no effect.

Set-less-than does not have a comparator of its own. It takes the sign of a subtraction from the shared adder and corrects that sign for overflow. The load-upper-immediate operation is one setting of the constant shifter: the immediate moves up by sixteen bits. The result is held in an output register and is accompanied by a zero flag and a sign flag. Branch evaluation uses the zero flag for the equal and not-equal tests and the sign flag for the test on operand sign.

Top module: `mf_alu`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the outputs go to `result_o` = 0, `zero_o` = 1 and `sign_o` = 0.
- R2: Class `fn_class_i` = 2'b10 is arithmetic. `result_o` is (x + y) mod 2^32 when `sub_i` = 0, and (x − y) mod 2^32 when `sub_i` = 1.
- R3: Class 2'b01 is set-less-than. `result_o` is 32'd1 when x < y as signed two's-complement numbers, and 32'd0 otherwise. The result is correct even when x − y overflows, and `sub_i` has no effect in this class.
- R4: Class 2'b11 is logic. `logic_i` selects the function: 2'b00 gives x AND y, 2'b01 gives x OR y, 2'b10 gives x XOR y, and 2'b11 gives NOR.
- R5: Class 2'b00 is the constant shifter. `y_i` is shifted logically by 8 × `shift_i[1:0]` bit positions, to the left when `shift_i[2]` = 0 and to the right when `shift_i[2]` = 1. The code `shift_i` = 3'b010 therefore gives `{y[15:0], 16'h0000}`, which is load-upper-immediate.
- R6: `zero_o` is 1 exactly when `result_o` is all zeros.
- R7: `sign_o` equals bit 31 of the `x_i` captured with the result, whatever the class.
- R8: The outputs change only at a rising edge of `clk`. Each output reflects the inputs sampled at that edge, so there is one cycle of latency.
- R9: Fields that the selected class does not use have no effect. `logic_i` and `shift_i` are ignored in the arithmetic class, and `sub_i` and `shift_i` are ignored in the logic class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs are registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_i | input | 32 | First operand |
| y_i | input | 32 | Second operand; the shifter also uses it as the immediate |
| fn_class_i | input | 2 | Function class: 00 shift, 01 set-less-than, 10 arithmetic, 11 logic |
| sub_i | input | 1 | Adder mode: 0 add, 1 subtract |
| shift_i | input | 3 | Bit 2 sets direction (0 left, 1 right); bits 1:0 set the amount in steps of 8 |
| logic_i | input | 2 | Logic function: 00 AND, 01 OR, 10 XOR, 11 NOR |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered flag, high when the result is zero |
| sign_o | output | 1 | Registered copy of the most significant bit of `x_i` |

## Verification
The block has no state apart from its output register, so any internal fault shows up one clock edge after the vector that exposes it. A wrong adder carry-in breaks subtraction and set-less-than together. A missing overflow correction gives an inverted compare only when the operand signs differ and the difference wraps. A wrong shift amount decode corrupts the byte positions of the shifted immediate. The tests probe these cases directly, together with tests that vary the unused fields and a test that checks the outputs hold steady between edges.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W      = 32;
    localparam int SHIFT_AMT_W = 2;
    localparam int SHIFT_STEP  = 8;
    localparam int SHIFT_N     = 1 << SHIFT_AMT_W;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'b00,
        CLS_SLT   = 2'b01,
        CLS_ARITH = 2'b10,
        CLS_LOGIC = 2'b11
    } fn_class_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_XOR = 2'b10,
        LOP_NOR = 2'b11
    } logic_op_e;

    typedef struct packed {
        logic                   right;
        logic [SHIFT_AMT_W-1:0] amt;
    } shift_ctl_t;

    typedef struct packed {
        fn_class_e  cls;
        logic       sub;
        shift_ctl_t sh;
        logic_op_e  lop;
    } alu_ctrl_t;

    // Adder mode: set-less-than always forces subtraction.
    function automatic logic adder_sub(input alu_ctrl_t c);
        return c.sub | (c.cls == CLS_SLT);
    endfunction

    // Signed less-than from the sign bits of a subtraction x - y.
    function automatic logic signed_less(input logic xs, input logic ys,
                                         input logic ds);
        logic ovf;
        ovf = (xs ^ ys) & (ds ^ xs);
        return ds ^ ovf;
    endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = alu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         less
);
    import alu_pkg::*;

    logic [W-1:0] b_eff;

    // One adder: subtraction is a + ~b with the carry-in set.
    assign b_eff = b ^ {W{sub}};
    assign sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    assign less  = signed_less(a[W-1], b[W-1], sum[W-1]);

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = alu_pkg::DATA_W
) (
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  alu_pkg::logic_op_e op,
    output logic [W-1:0]       y
);
    import alu_pkg::*;

    logic [W-1:0] or_ab;

    assign or_ab = a | b;

    always_comb begin
        unique case (op)
            LOP_AND: y = a & b;
            LOP_OR:  y = or_ab;
            LOP_XOR: y = a ^ b;
            LOP_NOR: y = ~or_ab;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W    = alu_pkg::DATA_W,
    parameter int STEP = alu_pkg::SHIFT_STEP,
    parameter int AW   = alu_pkg::SHIFT_AMT_W
) (
    input  logic [W-1:0]  d,
    input  logic          right,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  q
);
    localparam int N = 1 << AW;

    logic [W-1:0] lcand [N];
    logic [W-1:0] rcand [N];

    // Every shift amount is a constant: the candidates are wiring only.
    for (genvar k = 0; k < N; k++) begin : g_amt
        if (k * STEP < W) begin : g_in
            assign lcand[k] = d << (k * STEP);
            assign rcand[k] = d >> (k * STEP);
        end else begin : g_out
            assign lcand[k] = '0;
            assign rcand[k] = '0;
        end
    end

    assign q = right ? rcand[amt] : lcand[amt];

endmodule

// File: rtl/mf_alu.sv
module mf_alu #(
    parameter int W = alu_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [1:0]   fn_class_i,
    input  logic         sub_i,
    input  logic [2:0]   shift_i,
    input  logic [1:0]   logic_i,
    output logic [W-1:0] result_o,
    output logic         zero_o,
    output logic         sign_o
);
    import alu_pkg::*;

    alu_ctrl_t    ctrl;
    logic [W-1:0] sum_w;
    logic         less_w;
    logic [W-1:0] logic_w;
    logic [W-1:0] shift_w;
    logic [W-1:0] nxt_res;

    assign ctrl.cls       = fn_class_e'(fn_class_i);
    assign ctrl.sub       = sub_i;
    assign ctrl.sh.right  = shift_i[2];
    assign ctrl.sh.amt    = shift_i[SHIFT_AMT_W-1:0];
    assign ctrl.lop       = logic_op_e'(logic_i);

    alu_adder #(.W(W)) u_add (
        .a    (x_i),
        .b    (y_i),
        .sub  (adder_sub(ctrl)),
        .sum  (sum_w),
        .less (less_w)
    );

    alu_logic #(.W(W)) u_lu (
        .a  (x_i),
        .b  (y_i),
        .op (ctrl.lop),
        .y  (logic_w)
    );

    alu_shifter #(.W(W), .STEP(SHIFT_STEP), .AW(SHIFT_AMT_W)) u_sh (
        .d     (y_i),
        .right (ctrl.sh.right),
        .amt   (ctrl.sh.amt),
        .q     (shift_w)
    );

    // Function-class output mux.
    always_comb begin
        unique case (ctrl.cls)
            CLS_SHIFT: nxt_res = shift_w;
            CLS_SLT:   nxt_res = {{(W-1){1'b0}}, less_w};
            CLS_ARITH: nxt_res = sum_w;
            CLS_LOGIC: nxt_res = logic_w;
            default:   nxt_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            zero_o   <= 1'b1;
            sign_o   <= 1'b0;
        end else begin
            result_o <= nxt_res;
            zero_o   <= (nxt_res == '0);
            sign_o   <= x_i[W-1];
        end
    end

endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
    parameter int W = alu_pkg::DATA_W
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] x_i,
    input logic [W-1:0] y_i,
    input logic [1:0]   fn_class_i,
    input logic         sub_i,
    input logic [2:0]   shift_i,
    input logic [1:0]   logic_i,
    input logic [W-1:0] result_o,
    input logic         zero_o,
    input logic         sign_o
);
    logic pv;

    always_ff @(posedge clk) begin
        if (rst) pv <= 1'b0;
        else     pv <= 1'b1;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (result_o == '0 && zero_o && !sign_o)); // R1

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
        (pv && $past(fn_class_i == 2'b10 && !sub_i))
            |-> result_o == $past(x_i + y_i)); // R2

    AST_SLT_BOOL: assert property (@(posedge clk) disable iff (rst)
        (pv && $past(fn_class_i == 2'b01)) |-> result_o[W-1:1] == '0); // R3

    AST_XOR_FUNC: assert property (@(posedge clk) disable iff (rst)
        (pv && $past(fn_class_i == 2'b11 && logic_i == 2'b10))
            |-> result_o == $past(x_i ^ y_i)); // R4

    AST_LUI_LOW: assert property (@(posedge clk) disable iff (rst)
        (pv && $past(fn_class_i == 2'b00 && shift_i == 3'b010))
            |-> result_o == {$past(y_i[15:0]), 16'h0000}); // R5

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        zero_o == (result_o == '0)); // R6

    AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (rst)
        pv |-> sign_o == $past(x_i[W-1])); // R7

endmodule

bind mf_alu alu_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .x_i        (x_i),
    .y_i        (y_i),
    .fn_class_i (fn_class_i),
    .sub_i      (sub_i),
    .shift_i    (shift_i),
    .logic_i    (logic_i),
    .result_o   (result_o),
    .zero_o     (zero_o),
    .sign_o     (sign_o)
);

// File: tb/tb_mf_alu.sv
`timescale 1ns/1ps
module tb_mf_alu;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] x_i, y_i;
    logic [1:0]  fn_class_i;
    logic        sub_i;
    logic [2:0]  shift_i;
    logic [1:0]  logic_i;
    logic [31:0] result_o;
    logic        zero_o, sign_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    mf_alu dut (
        .clk(clk), .rst(rst), .x_i(x_i), .y_i(y_i),
        .fn_class_i(fn_class_i), .sub_i(sub_i), .shift_i(shift_i),
        .logic_i(logic_i), .result_o(result_o), .zero_o(zero_o),
        .sign_o(sign_o)
    );

    function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y,
                                          input logic [1:0] c, input logic s,
                                          input logic [2:0] sh, input logic [1:0] lg);
        int amt;
        amt = 8 * int'(sh[1:0]);
        case (c)
            2'b00: return sh[2] ? (y >> amt) : (y << amt);
            2'b01: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            2'b10: return s ? (x - y) : (x + y);
            default: case (lg)
                2'b00: return x & y;
                2'b01: return x | y;
                2'b10: return x ^ y;
                default: return ~(x | y);
            endcase
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] x, input logic [31:0] y, input logic [1:0] c,
                         input logic s, input logic [2:0] sh, input logic [1:0] lg);
        @(negedge clk);
        x_i = x; y_i = y; fn_class_i = c; sub_i = s; shift_i = sh; logic_i = lg;
    endtask

    // Apply one vector, wait for the capturing edge, then check all outputs.
    task automatic run(input string req, input logic [31:0] x, input logic [31:0] y,
                       input logic [1:0] c, input logic s, input logic [2:0] sh,
                       input logic [1:0] lg);
        logic [31:0] e;
        e = model(x, y, c, s, sh, lg);
        drive(x, y, c, s, sh, lg);
        @(posedge clk); #1;
        chk(req, result_o, e);
        chk({req, " zero R6"}, {31'd0, zero_o}, {31'd0, e == 32'd0});
        chk({req, " sign R7"}, {31'd0, sign_o}, {31'd0, x[31]});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive(32'h8000_0001, 32'h5, 2'b10, 1'b0, 3'b000, 2'b00);
        @(posedge clk); #1;
        chk("R1 result", result_o, 32'h0);
        chk("R1 zero", {31'd0, zero_o}, 32'd1);
        chk("R1 sign", {31'd0, sign_o}, 32'd0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_arith();
        run("R2 add", 32'd5, 32'd7, 2'b10, 1'b0, 3'b000, 2'b00);
        run("R2 add wrap", 32'hFFFF_FFFF, 32'd1, 2'b10, 1'b0, 3'b000, 2'b00);
        run("R2 add msb", 32'h7FFF_FFFF, 32'd1, 2'b10, 1'b0, 3'b000, 2'b00);
        run("R2 sub", 32'd10, 32'd3, 2'b10, 1'b1, 3'b000, 2'b00);
        run("R2 sub neg", 32'd3, 32'd10, 2'b10, 1'b1, 3'b000, 2'b00);
        run("R2 sub equal", 32'h1234_5678, 32'h1234_5678, 2'b10, 1'b1, 3'b000, 2'b00);
    endtask

    task automatic t_slt();
        run("R3 neg<pos", 32'hFFFF_FFFF, 32'd1, 2'b01, 1'b1, 3'b000, 2'b00);
        run("R3 pos<neg", 32'd1, 32'hFFFF_FFFF, 2'b01, 1'b1, 3'b000, 2'b00);
        run("R3 ovf min<1", 32'h8000_0000, 32'd1, 2'b01, 1'b1, 3'b000, 2'b00);
        run("R3 ovf max<-1", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'b01, 1'b1, 3'b000, 2'b00);
        run("R3 equal", 32'd42, 32'd42, 2'b01, 1'b1, 3'b000, 2'b00);
        run("R3 sub_i low", 32'd2, 32'd9, 2'b01, 1'b0, 3'b000, 2'b00);
    endtask

    task automatic t_logic();
        for (int k = 0; k < 4; k++)
            run("R4 logic", 32'hF0F0_1234, 32'h0FF0_4321, 2'b11, 1'b0, 3'b000, 2'(k));
        run("R4 nor all ones", 32'hFFFF_0000, 32'h0000_FFFF, 2'b11, 1'b0, 3'b000, 2'b11);
    endtask

    task automatic t_shift();
        run("R5 lui", 32'h0, 32'h1234_ABCD, 2'b00, 1'b0, 3'b010, 2'b00);
        run("R5 pass", 32'h0, 32'h1234_ABCD, 2'b00, 1'b0, 3'b000, 2'b00);
        run("R5 left8", 32'h0, 32'h1234_ABCD, 2'b00, 1'b0, 3'b001, 2'b00);
        run("R5 left24", 32'h0, 32'h1234_ABCD, 2'b00, 1'b0, 3'b011, 2'b00);
        run("R5 right8", 32'h0, 32'h1234_ABCD, 2'b00, 1'b0, 3'b101, 2'b00);
        run("R5 right24", 32'h0, 32'h8234_ABCD, 2'b00, 1'b0, 3'b111, 2'b00);
        run("R5 lui zero", 32'h8000_0000, 32'hABCD_0000, 2'b00, 1'b0, 3'b010, 2'b00);
    endtask

    task automatic t_ignore();
        for (int k = 0; k < 8; k++)
            run("R9 arith", 32'hDEAD_0000, 32'h0000_BEEF, 2'b10, 1'b1, 3'(k), 2'(k));
        for (int k = 0; k < 8; k++)
            run("R9 logic", 32'hDEAD_0000, 32'h0000_BEEF, 2'b11, k[0], 3'(k), 2'b01);
    endtask

    task automatic t_latency();
        run("R8 first", 32'd100, 32'd1, 2'b10, 1'b0, 3'b000, 2'b00);
        drive(32'h8000_0000, 32'd7, 2'b11, 1'b0, 3'b000, 2'b00);
        #2;
        chk("R8 hold result", result_o, 32'd101);
        chk("R8 hold sign", {31'd0, sign_o}, 32'd0);
        @(posedge clk); #1;
        chk("R8 update", result_o, 32'h0);
        chk("R8 update sign", {31'd0, sign_o}, 32'd1);
    endtask

    initial begin
        x_i = '0; y_i = '0; fn_class_i = '0; sub_i = 0; shift_i = '0; logic_i = '0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        t_reset();
        t_arith();
        t_slt();
        t_logic();
        t_shift();
        t_ignore();
        t_latency();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule